// File: doc/BRIEF.md
# Periodic Channel Frame-Parity Launch Gate

This block sits between a host channel's programming logic and its transaction engine. Software arms a channel with a one-cycle enable strobe, together with the endpoint type and a parity select bit. The block owns the running frame counter, which counts microframes of 125 µs in high-speed operation and full frames otherwise. It advances on an external tick pulse. The block then decides when the transfer may start. It signals that moment with a one-cycle launch pulse and reports the frame number in which the launch happened.

Control and bulk transfers start as soon as they are armed. Isochronous and interrupt transfers are gated by frame parity. If the parity select matches the low bit of the current frame number, the transfer goes out in the current frame. If it does not match, the transfer is held until the next frame tick. The parity therefore chooses between "this frame" and "the next frame". A transfer armed late in a frame can still be sent in that frame, and a held transfer never waits longer than one tick.

A disable input withdraws a held transfer before it launches.

Top module: `frame_parity_gate`

## Requirements
- R1: `frame_num` is 0 after reset. It increments by one at each clock edge where `frame_tick` is high, wraps from 0x3FFF to 0, and otherwise holds its value.
- R2: Control (`ep_kind` = 2'b00) and bulk (`ep_kind` = 2'b10) transfers accepted in cycle t produce `launch` in cycle t+1 whatever the value of `odd_sel`, and `busy` stays low.
- R3: Isochronous (2'b01) and interrupt (2'b11) transfers whose `odd_sel` equals bit 0 of the effective frame number produce `launch` in cycle t+1, with `busy` staying low.
- R4: A periodic transfer whose `odd_sel` differs from the effective parity raises `busy` from cycle t+1. It launches in the cycle after the next clock edge where `frame_tick` is high, and `busy` drops in that same cycle.
- R5: The effective frame number used for the parity decision is the value after any tick that arrives in the same cycle as the enable strobe.
- R6: `launch` is high for exactly one cycle per transfer and is never high together with `busy`. `launch_frame` equals `frame_num` in every cycle in which `launch` is high, and holds its value otherwise.
- R7: `chan_dis` clears a held transfer without a launch, even if a tick arrives in the same cycle. An enable strobe that arrives together with `chan_dis` is discarded.
- R8: An enable strobe that arrives while `busy` is high is ignored. The held transfer keeps its parity and type, and no second launch occurs.
- R9: After reset `launch` and `busy` are low and `launch_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse marking a frame or microframe boundary |
| chan_en | input | 1 | One-cycle strobe arming the channel |
| chan_dis | input | 1 | Cancels a held transfer; also discards a same-cycle enable |
| ep_kind | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| odd_sel | input | 1 | Wanted frame parity for periodic types (1 = odd) |
| launch | output | 1 | One-cycle start pulse for the transaction engine |
| busy | output | 1 | A periodic transfer is held waiting for the next tick |
| launch_frame | output | 14 | Frame number in which the last launch fired |
| frame_num | output | 14 | Running frame or microframe counter |

## Verification
The bench aims at the cycle where an enable strobe and a tick coincide. A gate that tested parity against the stale frame number would hold a transfer that should go at once, or release one a frame early. It drives a mismatched arm on frame 0x3FFF so that the deferred launch must report frame 0; an off-by-one in the wrap would report 0x4000 truncated wrongly or hold for two ticks. It also hits the races between disable and tick and between disable and enable, where a wrong priority emits a launch that should have been cancelled. Finally it re-arms while a transfer is held, where a gate that overwrote the held request would fire twice or flip parity.

// File: rtl/frame_parity_gate.sv
module frame_parity_gate #(
  parameter int                FN_W     = 14,
  parameter int                KIND_W   = 2,
  parameter logic [KIND_W-1:0] KIND_ISO = 2'b01,
  parameter logic [KIND_W-1:0] KIND_INT = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              chan_en,
  input  logic              chan_dis,
  input  logic [KIND_W-1:0] ep_kind,
  input  logic              odd_sel,
  output logic              launch,
  output logic              busy,
  output logic [FN_W-1:0]   launch_frame,
  output logic [FN_W-1:0]   frame_num
);

  logic [FN_W-1:0] fn_q;
  logic [FN_W-1:0] lf_q;
  logic            busy_q;
  logic            launch_q;

  // Frame value that holds after this edge: a same-cycle tick counts.
  logic [FN_W-1:0] fn_next;
  assign fn_next = frame_tick ? fn_q + 1'b1 : fn_q;

  logic periodic, accept, go_now, defer, fire_late, fire;
  assign periodic  = (ep_kind == KIND_ISO) || (ep_kind == KIND_INT);
  assign accept    = chan_en && !chan_dis && !busy_q;
  assign go_now    = accept && (!periodic || (odd_sel == fn_next[0]));
  assign defer     = accept && !go_now;
  assign fire_late = busy_q && frame_tick && !chan_dis;
  assign fire      = go_now || fire_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q     <= '0;
      lf_q     <= '0;
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      fn_q     <= fn_next;
      launch_q <= fire;
      busy_q   <= defer || (busy_q && !frame_tick && !chan_dis);
      if (fire) lf_q <= fn_next;
    end
  end

  assign launch       = launch_q;
  assign busy         = busy_q;
  assign launch_frame = lf_q;
  assign frame_num    = fn_q;

endmodule

// File: rtl/frame_parity_gate_chk.sv
module frame_parity_gate_chk #(
  parameter int FN_W   = 14,
  parameter int KIND_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              chan_en,
  input logic              chan_dis,
  input logic [KIND_W-1:0] ep_kind,
  input logic              odd_sel,
  input logic              launch,
  input logic              busy,
  input logic [FN_W-1:0]   launch_frame,
  input logic [FN_W-1:0]   frame_num
);

  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> frame_num == $past(frame_num) + 1'b1);

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(frame_num));

  p_plain_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !chan_dis && !busy && !ep_kind[0]) |=> launch && !busy);

  p_late_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_tick && !chan_dis) |=> launch && !busy);

  p_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_tick && !chan_dis) |=> busy && !launch);

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && busy));

  p_frame_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> launch_frame == frame_num);

  p_tag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |-> $stable(launch_frame) || $rose(rst_n));

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chan_dis) |=> !launch && !busy);

  p_en_dis_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && chan_dis) |=> !launch && !busy);

endmodule

bind frame_parity_gate frame_parity_gate_chk #(.FN_W(FN_W), .KIND_W(KIND_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .chan_en(chan_en),
  .chan_dis(chan_dis), .ep_kind(ep_kind), .odd_sel(odd_sel), .launch(launch),
  .busy(busy), .launch_frame(launch_frame), .frame_num(frame_num)
);

// File: tb/test_frame_parity_gate.sv
`timescale 1ns/1ps
module test_frame_parity_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, chan_en = 1'b0, chan_dis = 1'b0, odd_sel = 1'b0;
  logic [1:0] ep_kind = 2'b00;
  logic launch, busy;
  logic [13:0] launch_frame, frame_num;

  always #2.5 clk = ~clk;

  frame_parity_gate i_frame_parity_gate (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .chan_en(chan_en),
    .chan_dis(chan_dis), .ep_kind(ep_kind), .odd_sel(odd_sel),
    .launch(launch), .busy(busy), .launch_frame(launch_frame), .frame_num(frame_num)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R9";

  // Behavioural reference
  int m_fn = 0, m_lf = 0, m_busy = 0, m_launch = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fn = 0; m_lf = 0; m_busy = 0; m_launch = 0;
    end else begin
      int nf;
      nf = frame_tick ? (m_fn + 1) % 16384 : m_fn;
      m_launch = 0;
      if (m_busy != 0) begin
        if (chan_dis) m_busy = 0;
        else if (frame_tick) begin m_launch = 1; m_lf = nf; m_busy = 0; end
      end else if (chan_en && !chan_dis) begin
        if (ep_kind == 2'b00 || ep_kind == 2'b10 || int'(odd_sel) == nf % 2) begin
          m_launch = 1; m_lf = nf;
        end else m_busy = 1;
      end
      m_fn = nf;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("launch", int'(launch), m_launch);
    chk("busy", int'(busy), m_busy);
    chk("launch_frame", int'(launch_frame), m_lf);
    chk("frame_num", int'(frame_num), m_fn);
  end

  task automatic cyc(bit t, bit e, bit d, logic [1:0] k, bit o);
    @(negedge clk);
    frame_tick = t; chan_en = e; chan_dis = d; ep_kind = k; odd_sel = o;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'b00, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    tag = "watchdog"; checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R9";
    chk("reset launch", int'(launch), 0);
    chk("reset busy", int'(busy), 0);
    chk("reset launch_frame", int'(launch_frame), 0);
    chk("reset frame_num", int'(frame_num), 0);
    rst_n = 1'b1;
    idle(2);
    tag = "R2";  // frame 0: control and bulk with odd_sel=1
    cyc(0, 1, 0, 2'b00, 1); idle(1);
    chk("R2 control launch", int'(launch), 1);
    cyc(0, 1, 0, 2'b10, 1); idle(1);
    chk("R2 bulk launch", int'(launch), 1);
    tag = "R3";
    cyc(0, 1, 0, 2'b01, 0); idle(2);
    cyc(1, 0, 0, 2'b00, 0);
    cyc(0, 1, 0, 2'b11, 1); idle(1);
    chk("R3 interrupt odd launch", int'(launch), 1);
    tag = "R4";  // frame 1, ask even
    cyc(0, 1, 0, 2'b01, 0); idle(4);
    chk("R4 held busy", int'(busy), 1);
    cyc(1, 0, 0, 2'b00, 0); idle(1);
    chk("R4 late launch", int'(launch), 1);
    chk("R4 launch frame", int'(launch_frame), 2);
    tag = "R5";  // frame 2, tick together with enable asking odd
    cyc(1, 1, 0, 2'b11, 1); idle(1);
    chk("R5 same-cycle tick launch", int'(launch), 1);
    chk("R5 frame", int'(launch_frame), 3);
    tag = "R7";
    cyc(0, 1, 0, 2'b01, 0); idle(2);
    cyc(0, 0, 1, 2'b00, 0); idle(1);
    chk("R7 cancel busy", int'(busy), 0);
    cyc(0, 1, 0, 2'b01, 0); idle(1);
    cyc(1, 0, 1, 2'b00, 0); idle(3);
    chk("R7 dis beats tick", int'(launch), 0);
    cyc(0, 1, 1, 2'b00, 0); idle(1);
    chk("R7 en with dis", int'(launch), 0);
    tag = "R8";  // frame 4, ask odd then re-arm with bulk
    cyc(0, 1, 0, 2'b01, 1);
    cyc(0, 1, 0, 2'b10, 0); idle(2);
    chk("R8 still held", int'(busy), 1);
    cyc(1, 0, 0, 2'b00, 0); idle(3);
    tag = "R1";
    for (int i = 0; i < 16378; i++) cyc(1, 0, 0, 2'b00, 0);
    idle(1);
    chk("R1 frame before wrap", int'(frame_num), 16383);
    tag = "R4";
    cyc(0, 1, 0, 2'b01, 0);
    cyc(1, 0, 0, 2'b00, 0); idle(1);
    chk("R4 wrap launch frame", int'(launch_frame), 0);
    tag = "R6";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 11) == 0,
          2'($urandom), 1'($urandom));
    idle(4);
    finish_run();
  end
endmodule